// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of every beat of a read or write burst for a 32-bit-wide SDRAM whose column address is 9 bits wide. A burst is opened by a one-cycle start pulse carrying the first column, a 3-bit length code and an ordering select. From the next clock on, the block emits one column per cycle, flags the final beat of a fixed-length burst, and stops early when a stop request arrives.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size. Within the block they either count upward with wrap-around or follow an XOR (interleaved) order. A full-page burst walks all 512 columns in ascending order, wrapping from the top column to zero, until it is stopped. The command sequencer drives the start and stop inputs and uses the column output and last flag to schedule its column commands.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `beat_vld_o` and `beat_last_o` are low and stay low until a start pulse is seen.
- R2: In the cycle after `start_i` is sampled high, `beat_vld_o` is high and `col_o` equals the `start_col_i` value sampled with it (beat 0) in every mode.
- R3: Length code `len_code_i`: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page; the reserved codes 3'b100, 3'b101 and 3'b110 give a 1-beat burst.
- R4: Sequential order (`ilv_i` = 0) for length L: beat k has low log2(L) bits equal to (start + k) mod L, and the column bits above them equal those of the start column.
- R5: Interleaved order (`ilv_i` = 1) for L of 2, 4 or 8: beat k has low log2(L) bits equal to the start's low bits XOR k, and the upper bits unchanged.
- R6: In full-page mode every beat adds one to all 9 column bits, wrapping from 511 to 0, and the burst continues without a last flag until a stop or a new start.
- R7: In full-page mode the value of `ilv_i` has no effect; the order is always sequential.
- R8: `beat_last_o` is high only on the final beat of a fixed-length burst; in the cycle after it, `beat_vld_o` is low unless a new start was sampled.
- R9: `stop_i` sampled high during a valid beat without a start makes that beat the final one, so `beat_vld_o` is low in the next cycle. `stop_i` while idle has no effect.
- R10: A start sampled in any cycle, including the last beat or the middle of a burst, has priority over the stop request and over continuation. Its beat 0 appears in the very next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new burst at this edge |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | Burst length code (see R3) |
| ilv_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| stop_i | input | 1 | Ends the running burst after the current beat |
| col_o | output | 9 | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is being presented on `col_o` |
| beat_last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The sweep covers every length code with both orderings and every low start offset under several upper column patterns. A design that let the count carry into the upper bits, or that confused the XOR and add orders, would give wrong columns from the second beat on. A full-page run started near the top of the array has to wrap from 511 to 0 and must ignore the interleave select; a design that masked full page like an 8-beat burst, or that raised a last flag, would be caught there. Back-to-back starts on the last beat, restarts in mid-burst, and stops both while busy and while idle test the control corners: a design that left a bubble, let a stop beat a start, or ran one beat past a stop would show the wrong value on the valid output.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Length codes accepted on len_code_i
  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;

  typedef enum logic [1:0] {
    ORD_SEQ  = 2'd0,
    ORD_XOR  = 2'd1,
    ORD_PAGE = 2'd2
  } order_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3
) (
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] mask_o,
  output order_e           order_o
);

  // Mask of the column bits that move inside a fixed burst of 2**lg beats
  function automatic logic [COL_W-1:0] f_mask(input int unsigned lg);
    logic [COL_W-1:0] m;
    m = '0;
    for (int b = 0; b < COL_W; b++) begin
      if (b < int'(lg)) m[b] = 1'b1;
    end
    return m;
  endfunction

  logic is_page;
  logic is_fixed;

  always_comb begin
    is_page  = (len_code_i == LEN_PAGE);
    is_fixed = (int'(len_code_i) <= MAX_LG);
  end

  always_comb begin
    if (is_page)       mask_o = '1;
    else if (is_fixed) mask_o = f_mask(int'(len_code_i));
    else               mask_o = '0;   // reserved codes: single beat
  end

  always_comb begin
    if (is_page)    order_o = ORD_PAGE;
    else if (ilv_i) order_o = ORD_XOR;
    else            order_o = ORD_SEQ;
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output order_e           order_o,
  output logic             ev_start_o,
  output logic             ev_stop_o,
  output logic             ev_end_o
);

  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] mask_q;
  order_e           order_q;

  // Named events, observed by the checker
  always_comb begin
    ev_start_o = start_i;
    ev_end_o   = active_q && (order_q != ORD_PAGE) && (idx_q == mask_q);
    ev_stop_o  = active_q && stop_i && !start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      order_q  <= ORD_SEQ;
    end else if (start_i) begin
      active_q <= 1'b1;
      base_q   <= start_col_i;
      idx_q    <= '0;
      mask_q   <= mask_i;
      order_q  <= order_i;
    end else if (active_q && (stop_i || ev_end_o)) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (active_q) begin
      idx_q    <= idx_q + 1'b1;
    end
  end

  always_comb begin
    active_o = active_q;
    base_o   = base_q;
    idx_o    = idx_q;
    mask_o   = mask_q;
    order_o  = order_q;
  end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);

  // Upward count wrapping inside the masked block
  function automatic logic [COL_W-1:0] f_seq(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    logic [COL_W-1:0] s;
    s = b + k;
    return (b & ~m) | (s & m);
  endfunction

  // XOR ordering inside the masked block
  function automatic logic [COL_W-1:0] f_xor(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k, input logic [COL_W-1:0] m);
    return (b & ~m) | ((b ^ k) & m);
  endfunction

  // Whole-row count, wraps at the top column
  function automatic logic [COL_W-1:0] f_page(
    input logic [COL_W-1:0] b, input logic [COL_W-1:0] k);
    return b + k;
  endfunction

  always_comb begin
    unique case (order_i)
      ORD_XOR:  col_o = f_xor(base_i, idx_i, mask_i);
      ORD_PAGE: col_o = f_page(base_i, idx_i);
      default:  col_o = f_seq(base_i, idx_i, mask_i);
    endcase
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o
);

  logic [COL_W-1:0] dec_mask;
  order_e           dec_order;
  logic             run_active;
  logic [COL_W-1:0] run_base;
  logic [COL_W-1:0] run_idx;
  logic [COL_W-1:0] run_mask;
  order_e           run_order;
  logic             ev_start;
  logic             ev_stop;
  logic             ev_end;

  burst_len_decode #(.COL_W(COL_W), .MAX_LG(MAX_LG)) u_dec (
    .len_code_i (len_code_i),
    .ilv_i      (ilv_i),
    .mask_o     (dec_mask),
    .order_o    (dec_order)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .order_i     (dec_order),
    .stop_i      (stop_i),
    .active_o    (run_active),
    .base_o      (run_base),
    .idx_o       (run_idx),
    .mask_o      (run_mask),
    .order_o     (run_order),
    .ev_start_o  (ev_start),
    .ev_stop_o   (ev_stop),
    .ev_end_o    (ev_end)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i  (run_base),
    .idx_i   (run_idx),
    .mask_i  (run_mask),
    .order_i (run_order),
    .col_o   (col_o)
  );

  always_comb begin
    beat_vld_o  = run_active;
    beat_last_o = ev_end;
  end

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             beat_last_o
);

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_vld_o);  // R8

  AST_START_LOADS_COL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (beat_vld_o && col_o == $past(start_col_i)));  // R2

  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last_o && !start_i) |=> !beat_vld_o);  // R8

  AST_STOP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && stop_i && !start_i) |=> !beat_vld_o);  // R9

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_vld_o && !start_i) |=> !beat_vld_o);  // R1

  AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !beat_last_o && !stop_i) |=> beat_vld_o);  // R6

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .beat_vld_o  (beat_vld_o),
  .beat_last_o (beat_last_o)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       beat_vld_o;
  logic       beat_last_o;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .start_col_i (start_col_i),
    .len_code_i (len_code_i), .ilv_i (ilv_i), .stop_i (stop_i),
    .col_o (col_o), .beat_vld_o (beat_vld_o), .beat_last_o (beat_last_o)
  );

  // Beats per code, 0 meaning full page (R3)
  function automatic int beats_of(input logic [2:0] code);
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  // Expected column, computed arithmetically (R4, R5, R6)
  function automatic int exp_col(input int st, input int len, input bit ilv, input int k);
    int off;
    int blk;
    if (len == 0) return (st + k) % 512;
    off = st % len;
    blk = st - off;
    if (ilv && len > 1) return blk + (off ^ k);
    return blk + ((off + k) % len);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse a start; returns at the negedge where beat 0 is shown
  task automatic do_start(input int st, input logic [2:0] code, input bit ilv);
    start_i = 1'b1; start_col_i = 9'(st); len_code_i = code; ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Check a fixed burst beat by beat, then the idle cycle after it
  task automatic fixed_burst(input int st, input logic [2:0] code, input bit ilv);
    int len;
    len = beats_of(code);
    do_start(st, code, ilv);
    for (int k = 0; k < len; k++) begin
      check(beat_vld_o == 1'b1, "R2/R3 valid", int'(beat_vld_o), 1);
      check(int'(col_o) == exp_col(st, len, ilv, k), ilv ? "R5 col" : "R4 col",
            int'(col_o), exp_col(st, len, ilv, k));
      check(beat_last_o == (k == len - 1), "R8 last", int'(beat_last_o), int'(k == len - 1));
      @(negedge clk);
    end
    check(beat_vld_o == 1'b0, "R8 idle after last", int'(beat_vld_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(beat_vld_o == 1'b0, "R1 valid", int'(beat_vld_o), 0);
    check(beat_last_o == 1'b0, "R1 last", int'(beat_last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(beat_vld_o == 1'b0, "R1 valid after release", int'(beat_vld_o), 0);

    // Sweep all codes, both orders, all low offsets, several upper patterns
    for (int c = 0; c < 7; c++) begin
      for (int o = 0; o < 2; o++) begin
        for (int u = 0; u < 3; u++) begin
          for (int lo = 0; lo < 8; lo++) begin
            int up;
            up = (u == 0) ? 0 : ((u == 1) ? 9'h0A8 : 9'h1F8);
            fixed_burst(up + lo, 3'(c), o[0]);
          end
        end
      end
    end

    // Full page, both ilv values: wrap across 511 -> 0, no last (R6, R7)
    for (int o = 0; o < 2; o++) begin
      do_start(505, 3'b111, o[0]);
      for (int k = 0; k < 530; k++) begin
        check(int'(col_o) == exp_col(505, 0, 1'b0, k), o ? "R7 col" : "R6 col",
              int'(col_o), exp_col(505, 0, 1'b0, k));
        check(beat_vld_o && !beat_last_o, "R6 running", int'(beat_last_o), 0);
        if (k == 529) stop_i = 1'b1;
        @(negedge clk);
      end
      stop_i = 1'b0;
      check(beat_vld_o == 1'b0, "R9 stop full page", int'(beat_vld_o), 0);
    end

    // Stop in the middle of an 8-beat burst (R9)
    do_start(16, 3'b011, 1'b0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check(int'(col_o) == 19, "R9 beat before stop", int'(col_o), 19);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(beat_vld_o == 1'b0, "R9 stopped", int'(beat_vld_o), 0);

    // Stop while idle does nothing (R9)
    stop_i = 1'b1;
    repeat (3) @(negedge clk);
    stop_i = 1'b0;
    check(beat_vld_o == 1'b0, "R9 idle stop", int'(beat_vld_o), 0);
    fixed_burst(6, 3'b010, 1'b0);

    // Back-to-back: start on the last beat, no gap (R10)
    do_start(3, 3'b001, 1'b0);
    @(negedge clk);
    check(beat_last_o == 1'b1, "R10 last of first", int'(beat_last_o), 1);
    start_i = 1'b1; start_col_i = 9'd37; len_code_i = 3'b010; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(beat_vld_o && int'(col_o) == exp_col(37, 4, 1'b1, k), "R10 chained",
            int'(col_o), exp_col(37, 4, 1'b1, k));
      @(negedge clk);
    end
    check(beat_vld_o == 1'b0, "R10 idle after chain", int'(beat_vld_o), 0);

    // Restart mid-burst, with stop asserted too: start wins (R10)
    do_start(100, 3'b011, 1'b1);
    @(negedge clk);
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 9'd250; len_code_i = 3'b011; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(beat_vld_o && int'(col_o) == exp_col(250, 8, 1'b0, k), "R10 restart",
            int'(col_o), exp_col(250, 8, 1'b0, k));
      @(negedge clk);
    end
    check(beat_vld_o == 1'b0, "R10 idle after restart", int'(beat_vld_o), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule